// File: doc/BRIEF.md
# MDIO Management Controller

This block is a clause-22 MDIO management master controlled through two 32-bit memory-mapped registers. The first register is the command register. Software programs it with a PHY address, a PHY register number, a direction flag and a host-clock range code, and sets a go bit in the same write. The controller then produces the MDC clock and shifts out a complete management frame on the MDIO pins. The frame starts with a preamble of ones and ends with sixteen data bits. The controller clears the go bit by itself when the frame is over.

For a write frame, the second register holds the sixteen data bits that are shifted out. For a read frame, the controller releases the line during turnaround and for the data phase. It samples the PHY on each rising MDC edge and writes the result into that same register when the frame ends. The range code selects the MDC divisor, which keeps MDC at about 2.5 MHz or below for any supported host clock.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset the command and data registers both read as zero, MDC is low and MDIO output enable is low.
- R2: The command register sits at byte address 0x10. Writing it with bit 0 set while idle starts a frame. Bit 0 reads 1 from the cycle after that write until the frame ends, and then reads 0.
- R3: Command register layout: bit 1 is the direction (1 = write frame, 0 = read frame), bits 4:2 hold the range code, bits 10:6 hold the register number and bits 15:11 hold the PHY address. The fields read back as written. Bit 5, bits 31:16 and any unmapped address read 0.
- R4: During a frame, the MDC period in host clocks is 42, 62, 16, 26, 102 and 124 for range codes 0 to 5. Codes 6 and 7 use 124.
- R5: A write frame carries, MSB first: 32 ones, 01, opcode 01, the PHY address, the register number, turnaround 10, then the 16 data bits taken from the data register (byte address 0x14, bits 15:0). Output enable stays high for all 64 bits.
- R6: A read frame carries the same header with opcode 10. Output enable is low for the two turnaround bits and the 16 data bits. The 16 bits sampled on MDC rising edges, MSB first, appear in data register bits 15:0 once bit 0 has cleared.
- R7: MDIO output and output enable change only when MDC falls, or at frame start while MDC is low. They are stable while MDC is high.
- R8: While a frame is in progress, writes to the command register and to the data register are ignored, and no second frame is queued.
- R9: Each frame has exactly 64 MDC rising edges. MDC is held low whenever no frame is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_addr | input | ADDR_W (8) | Register byte address |
| csr_wr_en | input | 1 | Register write strobe, one cycle |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data for csr_addr |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_o | output | 1 | MDIO value driven when enabled |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO value sampled from the line |

## Verification
The assertions assume that a write strobe lasts one host clock and that the address is stable during that clock. They also assume that mdio_i settles within one MDC half period after MDC falls, so a PHY response is valid at the next rising edge. The bench drives every register access from the falling host-clock edge for exactly one cycle. Its PHY model changes mdio_i only on MDC falling edges, so every sampled bit is settled long before the edge that captures it.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

   localparam int FLD_W   = 5;
   localparam int WORD_W  = 16;
   localparam int RANGE_W = 3;
   localparam int DIV_W   = 8;

   typedef struct packed {
      logic [FLD_W-1:0]   phy;
      logic [FLD_W-1:0]   regn;
      logic [RANGE_W-1:0] range;
      logic               wr;
   } mgmt_cmd_t;

   // MDC divisor in host clocks for each range code; unknown codes take the slowest
   function automatic logic [DIV_W-1:0] mdc_divisor(input logic [RANGE_W-1:0] code);
      logic [DIV_W-1:0] d;
      case (code)
         3'd0:    d = DIV_W'(42);
         3'd1:    d = DIV_W'(62);
         3'd2:    d = DIV_W'(16);
         3'd3:    d = DIV_W'(26);
         3'd4:    d = DIV_W'(102);
         default: d = DIV_W'(124);
      endcase
      return d;
   endfunction

endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div
   import mdio_mgmt_pkg::*;
#(
   parameter int CNT_W = DIV_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [CNT_W-1:0] half,
   output logic             mdc,
   output logic             rise_stb,
   output logic             fall_stb
);

   logic [CNT_W-1:0] cnt_q;
   logic             mdc_q;
   logic             wrap;

   assign wrap     = run && (cnt_q == half - CNT_W'(1));
   assign rise_stb = wrap && !mdc_q;
   assign fall_stb = wrap &&  mdc_q;
   assign mdc      = mdc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         mdc_q <= 1'b0;
      end else if (!run) begin
         cnt_q <= '0;
         mdc_q <= 1'b0;
      end else if (wrap) begin
         cnt_q <= '0;
         mdc_q <= ~mdc_q;
      end else begin
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
   import mdio_mgmt_pkg::*;
#(
   parameter int PRE_LEN = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              st_wr,
   input  logic [FLD_W-1:0]  st_phy,
   input  logic [FLD_W-1:0]  st_reg,
   input  logic [WORD_W-1:0] st_data,
   input  logic              rise_stb,
   input  logic              fall_stb,
   input  logic              mdio_i,
   output logic              busy,
   output logic              done,
   output logic              mdio_o,
   output logic              mdio_oe,
   output logic [WORD_W-1:0] rd_word
);

   localparam int FRAME_LEN = PRE_LEN + 2 + 2 + 2*FLD_W + 2 + WORD_W;
   localparam int IDX_W     = $clog2(FRAME_LEN + 1);
   localparam int TA_POS    = FRAME_LEN - WORD_W - 2;
   localparam int DATA_POS  = FRAME_LEN - WORD_W;
   localparam int LAST_POS  = FRAME_LEN - 1;

   logic [FRAME_LEN-1:0] sh_q;
   logic [FRAME_LEN-1:0] frame_c;
   logic [IDX_W-1:0]     idx_q;
   logic                 busy_q;
   logic                 wr_q;
   logic [WORD_W-1:0]    rd_q;
   logic                 at_last;

   assign frame_c = { {PRE_LEN{1'b1}}, 2'b01,
                      (st_wr ? 2'b01 : 2'b10),
                      st_phy, st_reg,
                      (st_wr ? 2'b10 : 2'b00),
                      (st_wr ? st_data : {WORD_W{1'b0}}) };

   assign at_last = (idx_q == IDX_W'(LAST_POS));
   assign busy    = busy_q;
   assign done    = busy_q && fall_stb && at_last;
   assign mdio_oe = busy_q && (wr_q || (idx_q < IDX_W'(TA_POS)));
   assign mdio_o  = mdio_oe && sh_q[FRAME_LEN-1];
   assign rd_word = rd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         wr_q   <= 1'b0;
         idx_q  <= '0;
         sh_q   <= '0;
         rd_q   <= '0;
      end else if (!busy_q) begin
         if (start) begin
            busy_q <= 1'b1;
            wr_q   <= st_wr;
            idx_q  <= '0;
            sh_q   <= frame_c;
            rd_q   <= '0;
         end
      end else begin
         if (rise_stb && !wr_q && (idx_q >= IDX_W'(DATA_POS)))
            rd_q <= {rd_q[WORD_W-2:0], mdio_i};
         if (fall_stb) begin
            if (at_last) begin
               busy_q <= 1'b0;
            end else begin
               idx_q <= idx_q + IDX_W'(1);
               sh_q  <= {sh_q[FRAME_LEN-2:0], 1'b0};
            end
         end
      end
   end

endmodule

// File: rtl/mdio_csr_block.sv
module mdio_csr_block
   import mdio_mgmt_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int CMD_OFS   = 'h10,
   parameter int DATA_OFS  = 'h14,
   parameter bit RDATA_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [31:0]       wdata,
   input  logic              busy,
   input  logic              done_rd,
   input  logic [WORD_W-1:0] rd_word,
   output logic [31:0]       rdata,
   output logic              start,
   output mgmt_cmd_t         launch,
   output mgmt_cmd_t         cmd,
   output logic [WORD_W-1:0] data_word
);

   logic       hit_cmd, hit_data;
   mgmt_cmd_t  cmd_q;
   logic [WORD_W-1:0] data_q;
   logic [31:0] rd_c;

   assign hit_cmd  = (addr == ADDR_W'(CMD_OFS));
   assign hit_data = (addr == ADDR_W'(DATA_OFS));

   assign launch.phy   = wdata[15:11];
   assign launch.regn  = wdata[10:6];
   assign launch.range = wdata[4:2];
   assign launch.wr    = wdata[1];

   assign start     = wr_en && hit_cmd && !busy && wdata[0];
   assign cmd       = cmd_q;
   assign data_word = data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q <= '0;
      end else if (wr_en && hit_cmd && !busy) begin
         cmd_q <= launch;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
      end else if (done_rd) begin
         data_q <= rd_word;
      end else if (wr_en && hit_data && !busy) begin
         data_q <= wdata[WORD_W-1:0];
      end
   end

   always_comb begin
      rd_c = '0;
      if (hit_cmd)
         rd_c = {16'h0, cmd_q.phy, cmd_q.regn, 1'b0, cmd_q.range, cmd_q.wr, busy};
      else if (hit_data)
         rd_c = {{(32-WORD_W){1'b0}}, data_q};
   end

   generate
      if (RDATA_REG) begin : g_rd_flop
         logic [31:0] rdata_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rdata_q <= '0;
            else        rdata_q <= rd_c;
         end
         assign rdata = rdata_q;
      end else begin : g_rd_comb
         assign rdata = rd_c;
      end
   endgenerate

endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
   import mdio_mgmt_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int CMD_OFS   = 'h10,
   parameter int DATA_OFS  = 'h14,
   parameter int PRE_LEN   = 32,
   parameter bit RDATA_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] csr_addr,
   input  logic              csr_wr_en,
   input  logic [31:0]       csr_wdata,
   output logic [31:0]       csr_rdata,
   output logic              mdc,
   output logic              mdio_o,
   output logic              mdio_oe,
   input  logic              mdio_i
);

   generate
      if (ADDR_W < 5) begin : g_bad_addr_w
         $error("ADDR_W too small for the register offsets");
      end
      if (CMD_OFS == DATA_OFS) begin : g_bad_ofs
         $error("command and data offsets must differ");
      end
      if (PRE_LEN < 1 || PRE_LEN > 64) begin : g_bad_pre
         $error("PRE_LEN out of range");
      end
   endgenerate

   logic              eng_busy, eng_done, start;
   logic              rise_stb, fall_stb;
   logic [WORD_W-1:0] rd_word, data_word;
   mgmt_cmd_t         launch, cmd;
   logic [DIV_W-1:0]  half;

   assign half = mdc_divisor(cmd.range) >> 1;

   mdio_csr_block #(
      .ADDR_W(ADDR_W), .CMD_OFS(CMD_OFS), .DATA_OFS(DATA_OFS), .RDATA_REG(RDATA_REG)
   ) u_csr (
      .clk(clk), .rst_n(rst_n), .addr(csr_addr), .wr_en(csr_wr_en), .wdata(csr_wdata),
      .busy(eng_busy), .done_rd(eng_done && !cmd.wr), .rd_word(rd_word),
      .rdata(csr_rdata), .start(start), .launch(launch), .cmd(cmd), .data_word(data_word)
   );

   mdio_clk_div #(.CNT_W(DIV_W)) u_div (
      .clk(clk), .rst_n(rst_n), .run(eng_busy), .half(half),
      .mdc(mdc), .rise_stb(rise_stb), .fall_stb(fall_stb)
   );

   mdio_frame_engine #(.PRE_LEN(PRE_LEN)) u_eng (
      .clk(clk), .rst_n(rst_n), .start(start), .st_wr(launch.wr),
      .st_phy(launch.phy), .st_reg(launch.regn), .st_data(data_word),
      .rise_stb(rise_stb), .fall_stb(fall_stb), .mdio_i(mdio_i),
      .busy(eng_busy), .done(eng_done), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
      .rd_word(rd_word)
   );

endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk #(
   parameter int ADDR_W   = 8,
   parameter int CMD_OFS  = 'h10,
   parameter int DATA_OFS = 'h14
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mdc,
   input logic              mdio_o,
   input logic              mdio_oe,
   input logic              busy,
   input logic              done,
   input logic              csr_wr_en,
   input logic [ADDR_W-1:0] csr_addr,
   input logic [31:0]       csr_wdata,
   input logic [15:0]       data_q
);

   // R9
   idle_mdc_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mdc);

   // R7
   stable_while_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

   // R2
   start_by_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(csr_wr_en && csr_addr == ADDR_W'(CMD_OFS) && csr_wdata[0]));

   // R8
   data_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done && csr_wr_en && csr_addr == ADDR_W'(DATA_OFS)) |=> $stable(data_q));

   // R1
   idle_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mdio_oe && !mdio_o));

endmodule

bind mdio_mgmt_ctrl mdio_mgmt_chk #(
   .ADDR_W(ADDR_W), .CMD_OFS(CMD_OFS), .DATA_OFS(DATA_OFS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
   .busy(eng_busy), .done(eng_done), .csr_wr_en(csr_wr_en), .csr_addr(csr_addr),
   .csr_wdata(csr_wdata), .data_q(data_word)
);

// File: tb/mdio_mgmt_ctrl_bench.sv
module mdio_mgmt_ctrl_bench;

   localparam logic [7:0] A_CMD  = 8'h10;
   localparam logic [7:0] A_DATA = 8'h14;
   // {wr, range, phy, reg, data/response}
   localparam logic [29:0] VEC [8] = '{
      {1'b1, 3'd0, 5'h01, 5'h00, 16'hA5C3},
      {1'b0, 3'd2, 5'h1F, 5'h1F, 16'h8001},
      {1'b1, 3'd3, 5'h10, 5'h15, 16'h0001},
      {1'b0, 3'd1, 5'h0A, 5'h02, 16'hFFFF},
      {1'b1, 3'd4, 5'h00, 5'h1F, 16'h7E18},
      {1'b0, 3'd5, 5'h15, 5'h0A, 16'h1234},
      {1'b1, 3'd6, 5'h03, 5'h04, 16'h0F0F},
      {1'b0, 3'd7, 5'h1C, 5'h11, 16'hC0DE}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  csr_addr = '0;
   logic        csr_wr_en = 1'b0;
   logic [31:0] csr_wdata = '0;
   logic [31:0] csr_rdata;
   logic        mdc, mdio_o, mdio_oe;
   logic        mdio_i = 1'b0;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   mdio_mgmt_ctrl u_mdio_mgmt_ctrl (
      .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_wr_en(csr_wr_en),
      .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .mdc(mdc), .mdio_o(mdio_o),
      .mdio_oe(mdio_oe), .mdio_i(mdio_i)
   );

   // PHY model: records the line at MDC rises, answers reads at MDC falls
   logic [15:0] phy_resp = '0;
   logic [63:0] cap = '0, oecap = '0;
   int rise_n = 0, neg_n = 0;
   longint t_r1 = 0, t_r2 = 0;

   always @(posedge mdc) begin
      cap   = {cap[62:0], mdio_o};
      oecap = {oecap[62:0], mdio_oe};
      if (rise_n == 0) t_r1 = $time;
      if (rise_n == 1) t_r2 = $time;
      rise_n = rise_n + 1;
   end

   always @(negedge mdc) begin
      if (neg_n + 1 >= 48 && neg_n + 1 < 64) mdio_i = phy_resp[63 - (neg_n + 1)];
      neg_n = neg_n + 1;
   end

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic csr_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      csr_addr = a; csr_wdata = d; csr_wr_en = 1'b1;
      @(negedge clk);
      csr_wr_en = 1'b0;
   endtask

   task automatic csr_read(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      csr_addr = a;
      #1 d = csr_rdata;
   endtask

   task automatic wait_idle();
      logic [31:0] r;
      for (int i = 0; i < 20000; i++) begin
         csr_read(A_CMD, r);
         if (!r[0]) break;
      end
   endtask

   function automatic int exp_div(input logic [2:0] c);
      case (c)
         3'd0: return 42;
         3'd1: return 62;
         3'd2: return 16;
         3'd3: return 26;
         3'd4: return 102;
         default: return 124;
      endcase
   endfunction

   function automatic logic [63:0] exp_frame(input logic w, input logic [4:0] p, input logic [4:0] r, input logic [15:0] d);
      return {32'hFFFF_FFFF, 2'b01, (w ? 2'b01 : 2'b10), p, r, (w ? 2'b10 : 2'b00), (w ? d : 16'h0)};
   endfunction

   task automatic clear_phy(input logic [15:0] resp);
      rise_n = 0; neg_n = 0; cap = '0; oecap = '0; phy_resp = resp; mdio_i = 1'b0;
   endtask

   task automatic run_vec(input logic [29:0] v);
      logic w; logic [2:0] c; logic [4:0] p, r; logic [15:0] d;
      logic [31:0] rd, cmdw;
      logic [63:0] ef;
      {w, c, p, r, d} = v;
      clear_phy(d);
      if (w) csr_write(A_DATA, {16'h0, d});
      cmdw = {16'h0, p, r, 1'b0, c, w, 1'b1};
      csr_write(A_CMD, cmdw);
      csr_read(A_CMD, rd);
      check(rd == cmdw, "R2 busy/R3 fields during frame", 64'(rd), 64'(cmdw));
      wait_idle();
      csr_read(A_CMD, rd);
      check(rd == (cmdw & ~32'h1), "R2 busy cleared, R3 fields kept", 64'(rd), 64'(cmdw & ~32'h1));
      check(rise_n == 64, "R9 rising edges per frame", 64'(rise_n), 64'd64);
      check((t_r2 - t_r1) / 20 == exp_div(c), "R4 MDC period", 64'((t_r2 - t_r1) / 20), 64'(exp_div(c)));
      ef = exp_frame(w, p, r, d);
      if (w) begin
         check(cap == ef, "R5 write frame bits", cap, ef);
         check(oecap == {64{1'b1}}, "R5 write enable pattern", oecap, {64{1'b1}});
      end else begin
         check(cap[63:18] == ef[63:18], "R6 read header bits", 64'(cap[63:18]), 64'(ef[63:18]));
         check(oecap == {{46{1'b1}}, 18'h0}, "R6 read enable pattern", oecap, {{46{1'b1}}, 18'h0});
         csr_read(A_DATA, rd);
         check(rd == {16'h0, d}, "R6 read data captured", 64'(rd), 64'(d));
      end
      check(!mdc && !mdio_oe, "R9 MDC low and line released when idle", {62'h0, mdc, mdio_oe}, 64'h0);
   endtask

   initial begin
      logic [31:0] rd;
      int saved;
      repeat (3) @(negedge clk);
      // R1 reset state
      csr_read(A_CMD, rd);
      check(rd == 32'h0, "R1 command reg after reset", 64'(rd), 64'h0);
      csr_read(A_DATA, rd);
      check(rd == 32'h0, "R1 data reg after reset", 64'(rd), 64'h0);
      check(!mdc && !mdio_oe, "R1 pins after reset", {62'h0, mdc, mdio_oe}, 64'h0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(!mdc && !mdio_oe, "R9 idle pins", {62'h0, mdc, mdio_oe}, 64'h0);

      for (int i = 0; i < 8; i++) run_vec(VEC[i]);

      // R3 unmapped address and reserved bits
      csr_read(8'h18, rd);
      check(rd == 32'h0, "R3 unmapped address reads 0", 64'(rd), 64'h0);
      csr_write(A_CMD, 32'hFFFF_FFFE);
      csr_read(A_CMD, rd);
      check(rd == 32'h0000_FFDE, "R3 reserved bits read 0", 64'(rd), 64'h0000_FFDE);

      // R8 writes ignored while a frame runs
      clear_phy(16'h0);
      csr_write(A_DATA, 32'h0000_1111);
      csr_write(A_CMD, {16'h0, 5'h02, 5'h03, 1'b0, 3'd2, 1'b1, 1'b1});
      repeat (20) @(negedge clk);
      csr_write(A_DATA, 32'h0000_BEEF);
      csr_write(A_CMD, {16'h0, 5'h1E, 5'h1D, 1'b0, 3'd0, 1'b0, 1'b1});
      wait_idle();
      csr_read(A_DATA, rd);
      check(rd == 32'h1111, "R8 data reg kept during frame", 64'(rd), 64'h1111);
      csr_read(A_CMD, rd);
      check(rd == {16'h0, 5'h02, 5'h03, 1'b0, 3'd2, 1'b1, 1'b0}, "R8 command reg kept",
            64'(rd), 64'({16'h0, 5'h02, 5'h03, 1'b0, 3'd2, 1'b1, 1'b0}));
      check(cap == exp_frame(1'b1, 5'h02, 5'h03, 16'h1111), "R8 frame unaffected", cap,
            exp_frame(1'b1, 5'h02, 5'h03, 16'h1111));
      saved = rise_n;
      repeat (300) @(negedge clk);
      check(rise_n == saved && !mdc, "R8 no queued frame", 64'(rise_n), 64'(saved));

      // R7 a frame written without the go bit starts nothing
      csr_write(A_CMD, {16'h0, 5'h04, 5'h05, 1'b0, 3'd2, 1'b1, 1'b0});
      repeat (100) @(negedge clk);
      check(rise_n == saved && !mdio_oe, "R2 no start without go bit", 64'(rise_n), 64'(saved));

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(20 * 150000);
      if (!finished) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule